// File: doc/BRIEF.md
# Serial Port Baud Tick Generator with Run-Gated Divider Reload

This block makes the 16x oversampling tick for an asynchronous serial port from the system clock. It also holds the frame-format control word that the transmit and receive shifters read. The shifters themselves are not part of this block. The tick period comes from two stages. A small prescaler divides the system clock by 2, by 3 or by 1. A reload counter then divides the prescaled enable by (divider + 1).

Software programs a rate in three steps. It clears the run bit in the control word, writes the divider register, and sets the run bit again. While run is high, the divider register is frozen. While run is low, the generator is silent. The rising edge of run restarts both stages from the stored divider. For the standard setting, software stores (clock / (16 × baud)) / 2 − 1.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick_o, run_o and every decoded format output are 0, and cfg_word_o reads 0.
- R2: Control word bits [2:0] hold the data mode. Value 2 drives seven_bit_o high (7-bit frames). Every other value, including 0 and 3, drives it low (8-bit frames).
- R3: Control word bit 5 drives odd_par_o, and bit 7 drives two_stop_o. A control write updates these outputs at the next clock edge.
- R4: Control word bit 17 drives frm_chk_o, bit 19 drives ovr_chk_o, and bit 20 drives tmo_chk_o.
- R5: Control word bit 15 is the run bit, shown on run_o. While run is low, tick_o never pulses, and it is low from the first cycle after run is cleared.
- R6: A divider write takes effect only while run is low. A divider write while run is high is ignored, so the running period is unchanged and later runs still use the old value.
- R7: With bit 8 (rate select) at 0 and bit 9 (fractional enable) at 0, the tick period is 2 × (divider + 1) clocks.
- R8: With bit 8 at 1 and bit 9 at 0, the tick period is 3 × (divider + 1) clocks.
- R9: With bit 9 at 1, the prescaler is bypassed and the period is divider + 1 clocks, whatever bit 8 holds.
- R10: The clock edge that sets run restarts the counters. The first tick is visible exactly one full period after that edge, each tick lasts one clock unless the period is one clock, and later ticks follow one period apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| div_we | input | 1 | Divider write strobe (honoured only while run is low) |
| div_wdata | input | DIV_W | Divider write data |
| cfg_word_o | output | 32 | Stored control word |
| run_o | output | 1 | Run bit |
| seven_bit_o | output | 1 | 7-bit data frames selected |
| odd_par_o | output | 1 | Odd parity selected |
| two_stop_o | output | 1 | Two stop bits selected |
| frm_chk_o | output | 1 | Framing-error check enable |
| ovr_chk_o | output | 1 | Overrun check enable |
| tmo_chk_o | output | 1 | Timeout check enable |
| tick_o | output | 1 | One-clock 16x oversampling tick |

## Verification
The bench computes the cycle of every tick and compares it with the cycle in which the tick appears. Any fault shows up within one tick period as an early tick, a late tick or an extra tick:
- a prescaler that counts wrong or does not restart;
- a reload counter loaded with a stale divider;
- a divider register that accepts a write while running.

A run gate that leaks shows up as a tick during an idle window, within a few clocks of run going low. A bad decode of the control word shows on the format outputs in the cycle right after the write.

// File: rtl/bg_pkg.sv
package bg_pkg;

  localparam int CW        = 32;
  localparam int MODE_LSB  = 0;
  localparam int MODE_W    = 3;
  localparam logic [MODE_W-1:0] MODE_SEVEN = 3'd2;
  localparam int ODD_BIT   = 5;
  localparam int STOP_BIT  = 7;
  localparam int RATE_BIT  = 8;
  localparam int FRAC_BIT  = 9;
  localparam int RUN_BIT   = 15;
  localparam int NCHK      = 3;
  localparam int CHK_POS [NCHK] = '{17, 19, 20};
  localparam int PRE_STD   = 2;
  localparam int PRE_SLOW  = 3;

  typedef struct packed {
    logic            seven;
    logic            odd;
    logic            stop2;
    logic            rate;
    logic            frac;
    logic            run;
    logic [NCHK-1:0] chk;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [CW-1:0] w);
    fmt_t f;
    f.seven = (w[MODE_LSB +: MODE_W] == MODE_SEVEN);
    f.odd   = w[ODD_BIT];
    f.stop2 = w[STOP_BIT];
    f.rate  = w[RATE_BIT];
    f.frac  = w[FRAC_BIT];
    f.run   = w[RUN_BIT];
    for (int i = 0; i < NCHK; i++) f.chk[i] = w[CHK_POS[i]];
    return f;
  endfunction

endpackage

// File: rtl/bg_rst_sync.sv
module bg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/bg_ctl_regs.sv
module bg_ctl_regs
  import bg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CW-1:0]    ctl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [CW-1:0]    ctl_q,
  output fmt_t             fmt,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_nxt
);
  logic [CW-1:0] ctl_nxt;
  logic          ctl_en;
  logic          div_en;

  assign fmt = decode_fmt(ctl_q);

  always_comb begin
    ctl_en  = ctl_we;
    div_en  = div_we & ~fmt.run;
    ctl_nxt = ctl_en ? ctl_wdata : ctl_q;
    div_nxt = div_en ? div_wdata : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      div_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_nxt;
      if (div_en) div_q <= div_nxt;
    end
  end

  // R6: divider frozen while running
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt.run |=> $stable(div_q));

  // R3: a control write lands at the next edge
  p_ctl_land_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(ctl_wdata)));
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale
  import bg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate,
  input  logic frac,
  output logic en
);
  localparam int CNTW = $clog2(PRE_SLOW);
  localparam logic [CNTW-1:0] LIM_STD  = CNTW'(PRE_STD - 1);
  localparam logic [CNTW-1:0] LIM_SLOW = CNTW'(PRE_SLOW - 1);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_nxt;
  logic [CNTW-1:0] lim;
  logic            wrap;

  always_comb begin
    if (frac)      lim = '0;
    else if (rate) lim = LIM_SLOW;
    else           lim = LIM_STD;
    wrap = (cnt_q >= lim);
    en   = run & wrap;
    if (!run)      cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R8: prescale count never passes the slowest ratio
  p_pre_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNTW'(PRE_SLOW));

  // R5: prescaler rests at zero while stopped
  p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/bg_divcnt.sv
module bg_divcnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] load_val,
  output logic             tick_q
);
  logic [DIV_W-1:0] dcnt_q;
  logic [DIV_W-1:0] dcnt_nxt;
  logic             zero;
  logic             tick_nxt;

  always_comb begin
    zero     = (dcnt_q == '0);
    tick_nxt = run & en & zero;
    if (!run)      dcnt_nxt = load_val;
    else if (!en)  dcnt_nxt = dcnt_q;
    else if (zero) dcnt_nxt = load_val;
    else           dcnt_nxt = dcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_nxt;
      tick_q <= tick_nxt;
    end
  end

  // R10: reload counter stays within the programmed divider while running
  p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dcnt_q <= load_val));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [31:0]      cfg_word_o,
  output logic             run_o,
  output logic             seven_bit_o,
  output logic             odd_par_o,
  output logic             two_stop_o,
  output logic             frm_chk_o,
  output logic             ovr_chk_o,
  output logic             tmo_chk_o,
  output logic             tick_o
);
  logic             rst_ns;
  fmt_t             fmt;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  logic             pre_en;
  logic             tick_q;

  bg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  bg_ctl_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .ctl_q(cfg_word_o), .fmt(fmt), .div_q(div_q), .div_nxt(div_nxt)
  );

  bg_prescale u_pre (
    .clk(clk), .rst_n(rst_ns), .run(fmt.run),
    .rate(fmt.rate), .frac(fmt.frac), .en(pre_en)
  );

  bg_divcnt #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_ns), .run(fmt.run), .en(pre_en),
    .load_val(div_nxt), .tick_q(tick_q)
  );

  assign tick_o      = tick_q & fmt.run;
  assign run_o       = fmt.run;
  assign seven_bit_o = fmt.seven;
  assign odd_par_o   = fmt.odd;
  assign two_stop_o  = fmt.stop2;
  assign frm_chk_o   = fmt.chk[0];
  assign ovr_chk_o   = fmt.chk[1];
  assign tmo_chk_o   = fmt.chk[2];

  // R10: no tick in the cycle right after run rises
  p_first_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(fmt.run) |-> !tick_o);

  // R5: stopped generator stays silent the next cycle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    !fmt.run |=> !tick_o);

  // R6: divider unchanged across a running cycle
  p_div_frozen_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (fmt.run && $past(fmt.run)) |-> (div_q == $past(div_q)));
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int DIV_W = 16;
  localparam logic [31:0] RUN  = 32'h0000_8000;
  localparam logic [31:0] RATE = 32'h0000_0100;
  localparam logic [31:0] FRAC = 32'h0000_0200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_we = 1'b0;
  logic [31:0]      ctl_wdata = '0;
  logic             div_we = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic [31:0]      cfg_word_o;
  logic run_o, seven_bit_o, odd_par_o, two_stop_o;
  logic frm_chk_o, ovr_chk_o, tmo_chk_o, tick_o;

  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  int exp_q[$];
  int exp_front;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen #(.DIV_W(DIV_W)) i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .cfg_word_o(cfg_word_o),
    .run_o(run_o), .seven_bit_o(seven_bit_o), .odd_par_o(odd_par_o),
    .two_stop_o(two_stop_o), .frm_chk_o(frm_chk_o), .ovr_chk_o(ovr_chk_o),
    .tmo_chk_o(tmo_chk_o), .tick_o(tick_o)
  );

  // monitor: every tick must match the next scheduled cycle
  always @(negedge clk) begin
    if (rst_n && tick_o) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 tick at cycle %0d, expected none", cyc);
      end else begin
        exp_front = exp_q.pop_front();
        if (exp_front != cyc) begin
          fails++;
          $display("FAIL R10 tick at cycle %0d, expected %0d", cyc, exp_front);
        end
      end
    end
  end

  task automatic chk(input string tag, input int got, input int expv);
    vectors++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic int period(input logic [31:0] w, input int d);
    if (w[9])      return d + 1;
    else if (w[8]) return 3 * (d + 1);
    else           return 2 * (d + 1);
  endfunction

  task automatic wr_ctl(input logic [31:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_div(input int d);
    div_we = 1'b1; div_wdata = DIV_W'(d);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic settle(input string tag);
    repeat (12) @(negedge clk);
    chk(tag, exp_q.size(), 0);
  endtask

  // schedule ticks, start, run L cycles, stop
  task automatic run_seg(input string tag, input logic [31:0] w, input int d,
                         input int len, input bit load);
    int c0;
    int t;
    if (load) wr_div(d);
    t  = period(w, d);
    c0 = cyc + 1;
    for (int k = 1; k * t < len; k++) exp_q.push_back(c0 + k * t);
    wr_ctl(w | RUN);
    chk({tag, " run_o"}, run_o, 1);
    wait_cyc(c0 + len - 1);
    wr_ctl(w);
    chk("R5 tick off after stop", tick_o, 0);
    settle(tag);
  endtask

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tick", tick_o, 0);
    chk("R1 run", run_o, 0);
    chk("R1 word", int'(cfg_word_o), 0);
    chk("R1 fmt", int'({seven_bit_o, odd_par_o, two_stop_o, frm_chk_o, ovr_chk_o, tmo_chk_o}), 0);

    wr_ctl(32'h0002_0022);
    chk("R2 mode2 seven", seven_bit_o, 1);
    chk("R3 odd", odd_par_o, 1);
    chk("R3 stop", two_stop_o, 0);
    chk("R4 frm", frm_chk_o, 1);
    chk("R4 ovr", ovr_chk_o, 0);
    wr_ctl(32'h0018_0083);
    chk("R2 mode3 eight", seven_bit_o, 0);
    chk("R3 stop2", two_stop_o, 1);
    chk("R3 odd off", odd_par_o, 0);
    chk("R4 ovr", ovr_chk_o, 1);
    chk("R4 tmo", tmo_chk_o, 1);
    chk("R4 frm off", frm_chk_o, 0);
    wr_ctl(32'h0000_0000);
    chk("R2 mode0 eight", seven_bit_o, 0);
    repeat (20) @(negedge clk);
    chk("R5 idle no run", run_o, 0);

    run_seg("R7 div4", 32'h0, 4, 55, 1'b1);
    run_seg("R7 div0", 32'h0, 0, 21, 1'b1);
    run_seg("R8 slow div3", RATE, 3, 50, 1'b1);
    run_seg("R9 frac div5", FRAC, 5, 40, 1'b1);
    run_seg("R9 frac rate div2", FRAC | RATE, 2, 20, 1'b1);
    run_seg("R10 period one", FRAC, 0, 8, 1'b1);

    // R6: divider write while running is ignored
    wr_div(4);
    c0 = cyc + 1;
    for (int k = 1; k * 10 < 80; k++) exp_q.push_back(c0 + k * 10);
    wr_ctl(RUN);
    wait_cyc(c0 + 23);
    wr_div(1);
    wait_cyc(c0 + 79);
    wr_ctl(32'h0);
    settle("R6 running write");
    run_seg("R6 old divider kept", 32'h0, 4, 45, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule